// File: doc/BRIEF.md
# Pulse-Width Time Code Frame Decoder

This block takes a level-coded serial time code that is already synchronous to the system clock. It measures the high time of every pulse and sorts each pulse into one of three symbol kinds. It finds the start of each one-second frame from a pair of adjacent marker symbols. It then reads the seconds, minutes, hours, day-of-year and optional year as BCD digits. While the block is locked, it emits a one-cycle strobe at the rising edge that opens each frame. Once a complete frame has arrived with clean markers and legal digits, it latches that frame's time and raises a valid flag.

Pulse widths are counted in ticks. A tick is one cycle of an internal clock-enable that divides the system clock by `TICK_DIV`. With the default of 12500 at 125 MHz, one tick is 0.1 ms, so the nominal widths are 20, 50 and 80 ticks. A frame holds 100 symbol slots. Slot 0 is the reference marker. Slots 9, 19, …, 99 carry position markers.

Top module: `irigb_dcls_decoder`

## Requirements
- R1: After reset, `locked`, `time_valid` and `on_time` are all 0.
- R2: A high pulse of width w ticks is a zero if |w-ZERO_TICKS| <= TOL_TICKS, a one if |w-ONE_TICKS| <= TOL_TICKS, and a marker if |w-MARK_TICKS| <= TOL_TICKS. The limits are inclusive. Any other width is illegal. An illegal pulse drops lock and clears `time_valid`.
- R3: When unlocked, a marker that directly follows another marker is taken as slot 0 and sets `locked`. The flag rises two clock edges after the first cycle in which the input is sampled low at the end of that marker.
- R4: While locked, slot s must carry a marker exactly when s = 0 or s mod 10 = 9. A data symbol in one of those slots drops lock and clears `time_valid`.
- R5: While locked, a marker in any other slot drops lock and clears `time_valid`.
- R6: `on_time` is high for exactly one cycle for the rising edge that opens slot 0 while locked. It is high in the cycle after the second clock edge at which the input is sampled high. At no other time is it high.
- R7: Digits are sent least significant bit first, and a one symbol carries a 1. The slots are: seconds units 1–4 and tens 6–8; minutes units 10–13 and tens 15–17; hours units 20–23 and tens 25–26; day units 30–33, tens 35–38 and hundreds 40–41; year units 50–53 and tens 55–58 (when HAS_YEAR = 1). The outputs are BCD with the units in the low nibble.
- R8: When the slot 99 marker is accepted, the result of the frame appears two edges after the marker's falling edge is sampled. `time_valid` rises only at that point.
- R9: If any decoded 4-bit digit is above 9, `time_valid` is cleared and the time outputs keep their previous values. Lock is kept.
- R10: Between frame completions, the time outputs do not change.
- R11: Data symbols without a preceding marker pair never set `locked`. The first valid time follows one full frame after lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| din | input | 1 | Level-coded time code, synchronous to clk |
| on_time | output | 1 | One-cycle strobe at the rising edge of the reference marker |
| locked | output | 1 | Frame alignment held |
| time_valid | output | 1 | Latched time comes from a clean, complete frame |
| sec_bcd | output | 7 | Seconds, BCD |
| min_bcd | output | 7 | Minutes, BCD |
| hour_bcd | output | 6 | Hours, BCD |
| day_bcd | output | 10 | Day of year, BCD |
| year_bcd | output | 8 | Year of century, BCD (zero when HAS_YEAR = 0) |

## Verification
Each symbol goes through two registers before the frame logic sees it. As a result, `locked` and `time_valid` change at the third falling clock edge after the input is driven low at the end of a pulse. `on_time` appears at the second falling edge after the input is driven high. The bench keeps a behavioural slot and lock model. On every clock it compares `on_time`, `locked` and `time_valid` with the old model state up to that due cycle, and with the new state from then on. Field values are compared at the start of each symbol, when the outputs have long settled.

// File: rtl/irigb_pkg.sv
package irigb_pkg;
  localparam int IRIG_SLOTS  = 100;
  localparam int IRIG_SLOT_W = $clog2(IRIG_SLOTS);

  typedef enum logic [1:0] {
    SYM_ZERO = 2'd0,
    SYM_ONE  = 2'd1,
    SYM_MARK = 2'd2,
    SYM_BAD  = 2'd3
  } irig_sym_e;

  typedef struct packed {
    logic [7:0] year;
    logic [9:0] day;
    logic [5:0] hour;
    logic [6:0] min;
    logic [6:0] sec;
  } irig_time_t;
endpackage

// File: rtl/irigb_width_meas.sv
module irigb_width_meas
  import irigb_pkg::*;
#(
  parameter int TICK_DIV = 12500,
  parameter int ZERO_T   = 20,
  parameter int ONE_T    = 50,
  parameter int MARK_T   = 80,
  parameter int TOL_T    = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      din,
  output logic      rise,
  output logic      sym_stb,
  output irig_sym_e sym
);
  localparam int CNT_MAX = MARK_T + TOL_T + 1;
  localparam int CW      = $clog2(CNT_MAX + 1);

  logic          tick;
  logic          din_q, din_prev_q, fall;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          stb_d;
  irig_sym_e     sym_d, sym_q;
  logic          stb_q;

  generate
    if (TICK_DIV <= 1) begin : g_tick_every
      assign tick = 1'b1;
    end else begin : g_tick_div
      localparam int DW = $clog2(TICK_DIV);
      logic [DW-1:0] div_q, div_d;
      always_comb begin
        div_d = (div_q == DW'(TICK_DIV - 1)) ? '0 : div_q + 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
      end
      assign tick = (div_q == DW'(TICK_DIV - 1));
    end
  endgenerate

  assign rise = din_q & ~din_prev_q;
  assign fall = ~din_q & din_prev_q;

  always_comb begin
    cnt_d = cnt_q;
    if (rise) begin
      cnt_d = tick ? CW'(1) : '0;
    end else if (din_q && tick && (cnt_q != CW'(CNT_MAX))) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_comb begin
    stb_d = fall;
    if (cnt_q >= CW'(ZERO_T - TOL_T) && cnt_q <= CW'(ZERO_T + TOL_T))
      sym_d = SYM_ZERO;
    else if (cnt_q >= CW'(ONE_T - TOL_T) && cnt_q <= CW'(ONE_T + TOL_T))
      sym_d = SYM_ONE;
    else if (cnt_q >= CW'(MARK_T - TOL_T) && cnt_q <= CW'(MARK_T + TOL_T))
      sym_d = SYM_MARK;
    else
      sym_d = SYM_BAD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_q      <= 1'b0;
      din_prev_q <= 1'b0;
      cnt_q      <= '0;
      stb_q      <= 1'b0;
      sym_q      <= SYM_ZERO;
    end else begin
      din_q      <= din;
      din_prev_q <= din_q;
      cnt_q      <= cnt_d;
      stb_q      <= stb_d;
      if (fall) sym_q <= sym_d;
    end
  end

  assign sym_stb = stb_q;
  assign sym     = sym_q;
endmodule

// File: rtl/irigb_frame_track.sv
module irigb_frame_track
  import irigb_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rise,
  input  logic                   sym_stb,
  input  irig_sym_e              sym,
  output logic                   locked,
  output logic                   on_time,
  output logic                   accept,
  output logic                   bit_val,
  output logic [IRIG_SLOT_W-1:0] slot,
  output logic                   frame_done,
  output logic                   lost
);
  localparam logic [IRIG_SLOT_W-1:0] LAST = IRIG_SLOT_W'(IRIG_SLOTS - 1);

  logic                   locked_q, locked_d;
  logic                   prev_mark_q, prev_mark_d;
  logic [IRIG_SLOT_W-1:0] slot_q, slot_d;
  logic                   on_time_q, on_time_d;
  logic                   is_mark, mark_slot;

  assign is_mark   = (sym == SYM_MARK);
  assign mark_slot = (slot_q == '0) || ((slot_q % IRIG_SLOT_W'(10)) == IRIG_SLOT_W'(9));

  always_comb begin
    locked_d    = locked_q;
    prev_mark_d = prev_mark_q;
    slot_d      = slot_q;
    accept      = 1'b0;
    frame_done  = 1'b0;
    lost        = 1'b0;
    if (sym_stb) begin
      prev_mark_d = is_mark;
      if (!locked_q) begin
        if (is_mark && prev_mark_q) begin
          locked_d = 1'b1;
          slot_d   = IRIG_SLOT_W'(1);
        end
      end else if ((sym == SYM_BAD) || (is_mark != mark_slot)) begin
        locked_d = 1'b0;
        lost     = 1'b1;
      end else begin
        accept = !is_mark;
        if (slot_q == LAST) begin
          slot_d     = '0;
          frame_done = 1'b1;
        end else begin
          slot_d = slot_q + 1'b1;
        end
      end
    end
    on_time_d = rise && locked_q && (slot_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q    <= 1'b0;
      prev_mark_q <= 1'b0;
      slot_q      <= '0;
      on_time_q   <= 1'b0;
    end else begin
      locked_q    <= locked_d;
      prev_mark_q <= prev_mark_d;
      slot_q      <= slot_d;
      on_time_q   <= on_time_d;
    end
  end

  assign locked  = locked_q;
  assign on_time = on_time_q;
  assign slot    = slot_q;
  assign bit_val = (sym == SYM_ONE);
endmodule

// File: rtl/irigb_time_latch.sv
module irigb_time_latch
  import irigb_pkg::*;
#(
  parameter int HAS_YEAR = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   accept,
  input  logic                   bit_val,
  input  logic [IRIG_SLOT_W-1:0] slot,
  input  logic                   frame_done,
  input  logic                   lost,
  output logic                   time_valid,
  output irig_time_t             time_out
);
  localparam bit USE_YEAR = (HAS_YEAR != 0);

  irig_time_t sh_q, sh_d, tm_q, tm_d;
  logic       valid_q, valid_d;
  logic       base_ok, year_ok;

  always_comb begin
    sh_d = sh_q;
    if (accept) begin
      if (slot >= 7'd1 && slot <= 7'd4)        sh_d.sec[3'(slot - 7'd1)]   = bit_val;
      else if (slot >= 7'd6 && slot <= 7'd8)   sh_d.sec[3'(slot - 7'd2)]   = bit_val;
      else if (slot >= 7'd10 && slot <= 7'd13) sh_d.min[3'(slot - 7'd10)] = bit_val;
      else if (slot >= 7'd15 && slot <= 7'd17) sh_d.min[3'(slot - 7'd11)] = bit_val;
      else if (slot >= 7'd20 && slot <= 7'd23) sh_d.hour[3'(slot - 7'd20)] = bit_val;
      else if (slot >= 7'd25 && slot <= 7'd26) sh_d.hour[3'(slot - 7'd21)] = bit_val;
      else if (slot >= 7'd30 && slot <= 7'd33) sh_d.day[4'(slot - 7'd30)] = bit_val;
      else if (slot >= 7'd35 && slot <= 7'd38) sh_d.day[4'(slot - 7'd31)] = bit_val;
      else if (slot >= 7'd40 && slot <= 7'd41) sh_d.day[4'(slot - 7'd32)] = bit_val;
      else if (USE_YEAR && slot >= 7'd50 && slot <= 7'd53) sh_d.year[3'(slot - 7'd50)] = bit_val;
      else if (USE_YEAR && slot >= 7'd55 && slot <= 7'd58) sh_d.year[3'(slot - 7'd51)] = bit_val;
    end
  end

  assign base_ok = (sh_q.sec[3:0] <= 4'd9) && (sh_q.min[3:0] <= 4'd9) &&
                   (sh_q.hour[3:0] <= 4'd9) && (sh_q.day[3:0] <= 4'd9) &&
                   (sh_q.day[7:4] <= 4'd9);

  generate
    if (HAS_YEAR != 0) begin : g_year_chk
      assign year_ok = (sh_q.year[3:0] <= 4'd9) && (sh_q.year[7:4] <= 4'd9);
    end else begin : g_year_none
      assign year_ok = 1'b1;
    end
  endgenerate

  always_comb begin
    valid_d = valid_q;
    tm_d    = tm_q;
    if (lost) begin
      valid_d = 1'b0;
    end else if (frame_done) begin
      valid_d = base_ok && year_ok;
      if (base_ok && year_ok) tm_d = sh_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      tm_q    <= '0;
      valid_q <= 1'b0;
    end else begin
      sh_q    <= sh_d;
      tm_q    <= tm_d;
      valid_q <= valid_d;
    end
  end

  assign time_valid = valid_q;
  assign time_out   = tm_q;
endmodule

// File: rtl/irigb_dcls_decoder.sv
module irigb_dcls_decoder
  import irigb_pkg::*;
#(
  parameter int TICK_DIV   = 12500,
  parameter int ZERO_TICKS = 20,
  parameter int ONE_TICKS  = 50,
  parameter int MARK_TICKS = 80,
  parameter int TOL_TICKS  = 4,
  parameter int HAS_YEAR   = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       din,
  output logic       on_time,
  output logic       locked,
  output logic       time_valid,
  output logic [6:0] sec_bcd,
  output logic [6:0] min_bcd,
  output logic [5:0] hour_bcd,
  output logic [9:0] day_bcd,
  output logic [7:0] year_bcd
);
  logic [1:0]             rst_pipe_q;
  logic                   rst_n_sync;
  logic                   rise, sym_stb;
  irig_sym_e              sym;
  logic                   accept, bit_val, frame_done, lost;
  logic [IRIG_SLOT_W-1:0] slot;
  irig_time_t             time_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe_q[1];

  irigb_width_meas #(
    .TICK_DIV(TICK_DIV), .ZERO_T(ZERO_TICKS), .ONE_T(ONE_TICKS),
    .MARK_T(MARK_TICKS), .TOL_T(TOL_TICKS)
  ) u_meas (
    .clk(clk), .rst_n(rst_n_sync), .din(din),
    .rise(rise), .sym_stb(sym_stb), .sym(sym)
  );

  irigb_frame_track u_track (
    .clk(clk), .rst_n(rst_n_sync), .rise(rise), .sym_stb(sym_stb), .sym(sym),
    .locked(locked), .on_time(on_time), .accept(accept), .bit_val(bit_val),
    .slot(slot), .frame_done(frame_done), .lost(lost)
  );

  irigb_time_latch #(.HAS_YEAR(HAS_YEAR)) u_latch (
    .clk(clk), .rst_n(rst_n_sync), .accept(accept), .bit_val(bit_val),
    .slot(slot), .frame_done(frame_done), .lost(lost),
    .time_valid(time_valid), .time_out(time_out)
  );

  assign sec_bcd  = time_out.sec;
  assign min_bcd  = time_out.min;
  assign hour_bcd = time_out.hour;
  assign day_bcd  = time_out.day;
  assign year_bcd = time_out.year;
endmodule

// File: rtl/irigb_dcls_checker.sv
module irigb_dcls_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       on_time,
  input logic       locked,
  input logic       time_valid,
  input logic       frame_done,
  input logic       lost,
  input logic [6:0] sec_bcd,
  input logic [6:0] min_bcd,
  input logic [5:0] hour_bcd,
  input logic [9:0] day_bcd,
  input logic [7:0] year_bcd
);
  p_ontime_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    on_time |-> $past(locked));

  p_ontime_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    on_time |=> !on_time);

  p_valid_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    time_valid |-> locked);

  p_lost_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lost |=> (!locked && !time_valid));

  p_valid_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(time_valid) |-> $past(frame_done));

  p_digits_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    time_valid |-> (sec_bcd[3:0] <= 4'd9 && min_bcd[3:0] <= 4'd9 &&
                    hour_bcd[3:0] <= 4'd9 && day_bcd[3:0] <= 4'd9 &&
                    day_bcd[7:4] <= 4'd9 && year_bcd[3:0] <= 4'd9 &&
                    year_bcd[7:4] <= 4'd9));

  p_fields_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_done) |-> $stable({sec_bcd, min_bcd, hour_bcd, day_bcd, year_bcd}));
endmodule

bind irigb_dcls_decoder irigb_dcls_checker u_chk (
  .clk(clk), .rst_n(rst_n_sync), .on_time(on_time), .locked(locked),
  .time_valid(time_valid), .frame_done(frame_done), .lost(lost),
  .sec_bcd(sec_bcd), .min_bcd(min_bcd), .hour_bcd(hour_bcd),
  .day_bcd(day_bcd), .year_bcd(year_bcd)
);

// File: tb/irigb_dcls_decoder_tb_top.sv
module irigb_dcls_decoder_tb_top;
  localparam int SYM_CYC = 100;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       din;
  logic       on_time, locked, time_valid;
  logic [6:0] sec_bcd, min_bcd;
  logic [5:0] hour_bcd;
  logic [9:0] day_bcd;
  logic [7:0] year_bcd;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  finished = 1'b0;
  string cur_req = "R1";

  // behavioural model state
  bit m_locked, m_valid, m_prev;
  int m_slot;
  int m_sec, m_min, m_hour, m_day, m_year;
  int p_sec, p_min, p_hour, p_day, p_year;

  always #4 clk = ~clk;

  irigb_dcls_decoder #(.TICK_DIV(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .din(din), .on_time(on_time), .locked(locked),
    .time_valid(time_valid), .sec_bcd(sec_bcd), .min_bcd(min_bcd),
    .hour_bcd(hour_bcd), .day_bcd(day_bcd), .year_bcd(year_bcd)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int fld_bit(input int s);
    case (s) inside
      [1:4]:   return (p_sec  >> (s - 1))  & 1;
      [6:8]:   return (p_sec  >> (s - 2))  & 1;
      [10:13]: return (p_min  >> (s - 10)) & 1;
      [15:17]: return (p_min  >> (s - 11)) & 1;
      [20:23]: return (p_hour >> (s - 20)) & 1;
      [25:26]: return (p_hour >> (s - 21)) & 1;
      [30:33]: return (p_day  >> (s - 30)) & 1;
      [35:38]: return (p_day  >> (s - 31)) & 1;
      [40:41]: return (p_day  >> (s - 32)) & 1;
      [50:53]: return (p_year >> (s - 50)) & 1;
      [55:58]: return (p_year >> (s - 51)) & 1;
      default: return 0;
    endcase
  endfunction

  function automatic bit digits_ok();
    return ((p_sec & 15) <= 9) && ((p_min & 15) <= 9) && ((p_hour & 15) <= 9) &&
           ((p_day & 15) <= 9) && (((p_day >> 4) & 15) <= 9) &&
           ((p_year & 15) <= 9) && (((p_year >> 4) & 15) <= 9);
  endfunction

  // kind: 0 zero, 1 one, 2 marker, 3 illegal width
  task automatic model_step(input int kind);
    if (!m_locked) begin
      if (kind == 2 && m_prev) begin m_locked = 1; m_slot = 1; end
    end else if (kind == 3 || ((kind == 2) != (m_slot == 0 || m_slot % 10 == 9))) begin
      m_locked = 0; m_valid = 0;
    end else if (m_slot == 99) begin
      m_slot = 0;
      m_valid = digits_ok();
      if (m_valid) begin
        m_sec = p_sec; m_min = p_min; m_hour = p_hour; m_day = p_day; m_year = p_year;
      end
    end else begin
      m_slot++;
    end
    m_prev = (kind == 2);
  endtask

  task automatic send_sym(input int h, input int kind);
    bit o_locked, o_valid, exp_ot;
    int o_sec, o_min, o_hour, o_day, o_year;
    o_locked = m_locked; o_valid = m_valid;
    o_sec = m_sec; o_min = m_min; o_hour = m_hour; o_day = m_day; o_year = m_year;
    exp_ot = m_locked && (m_slot == 0);
    model_step(kind);
    for (int i = 0; i < SYM_CYC; i++) begin
      @(negedge clk);
      if (i == 0 && o_valid) begin
        chk("R7,R10 sec", sec_bcd, o_sec);
        chk("R7,R10 min", min_bcd, o_min);
        chk("R7,R10 hour", hour_bcd, o_hour);
        chk("R7,R10 day", day_bcd, o_day);
        chk("R7,R10 year", year_bcd, o_year);
      end
      chk("R6 on_time", on_time, (i == 2 && exp_ot) ? 1 : 0);
      chk(cur_req, locked, (i >= h + 3) ? m_locked : o_locked);
      chk("R8 valid", time_valid, (i >= h + 3) ? m_valid : o_valid);
      din = (i < h);
    end
  endtask

  task automatic send_frame(input int sec, input int min, input int hour, input int day,
                            input int year, input int miss, input int xmark,
                            input int bad, input bit edgew);
    p_sec = sec; p_min = min; p_hour = hour; p_day = day; p_year = year;
    for (int s = 0; s < 100; s++) begin
      int k;
      int w;
      k = (s == 0 || s % 10 == 9) ? 2 : fld_bit(s);
      if (s == miss)  k = 0;
      if (s == xmark) k = 2;
      if (s == bad)   k = 3;
      case (k)
        0: w = edgew ? 24 : 20;
        1: w = edgew ? 46 : 50;
        2: w = 80;
        default: w = 25;
      endcase
      send_sym(w, k);
    end
  endtask

  initial begin
    din = 1'b0; rst_n = 1'b0;
    m_locked = 0; m_valid = 0; m_prev = 0; m_slot = 0;
    m_sec = 0; m_min = 0; m_hour = 0; m_day = 0; m_year = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 locked", locked, 0);
    chk("R1 valid", time_valid, 0);
    chk("R1 on_time", on_time, 0);
    // R11: data alone never locks; one marker alone never locks
    cur_req = "R11";
    send_sym(20, 0); send_sym(50, 1); send_sym(20, 0);
    send_sym(80, 2);
    // R3: lock on the marker pair, then first full frame gives time (R11)
    cur_req = "R3";
    send_frame('h56, 'h34, 'h12, 'h123, 'h24, -1, -1, -1, 1'b0);
    // R2: widths at the tolerance limits still decode
    cur_req = "R2";
    send_frame('h57, 'h34, 'h12, 'h123, 'h24, -1, -1, -1, 1'b1);
    // R9: seconds units digit 0xA
    cur_req = "R9";
    send_frame('h5A, 'h34, 'h12, 'h123, 'h24, -1, -1, -1, 1'b0);
    send_frame('h59, 'h34, 'h12, 'h123, 'h24, -1, -1, -1, 1'b0);
    // R4: marker missing at slot 39
    cur_req = "R4";
    send_frame('h00, 'h35, 'h12, 'h123, 'h24, 39, -1, -1, 1'b0);
    send_frame('h01, 'h35, 'h12, 'h123, 'h24, -1, -1, -1, 1'b0);
    // R5: marker inside a data slot
    cur_req = "R5";
    send_frame('h02, 'h35, 'h12, 'h123, 'h24, -1, 5, -1, 1'b0);
    send_frame('h03, 'h35, 'h12, 'h123, 'h24, -1, -1, -1, 1'b0);
    // R2: width of 25 ticks between the zero and one windows
    cur_req = "R2";
    send_frame('h04, 'h35, 'h12, 'h123, 'h24, -1, -1, 45, 1'b0);
    send_frame('h59, 'h59, 'h23, 'h366, 'h99, -1, -1, -1, 1'b0);
    send_sym(80, 2);
    chk("R7 final valid", time_valid, 1);
    chk("R7 final day", day_bcd, 'h366);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule